// File: doc/BRIEF.md
# Configurable Set/Reset Storage Flop

A single-bit storage element whose forcing behaviour is fixed at elaboration time. A primary force input drives the output to a level chosen by a parameter: either high or low. A secondary force input drives the opposite level. A parameter decides whether both force inputs act at the next rising clock edge or act at once, without waiting for the clock. The two inputs can be enabled separately. Together these choices give seven modes: `MD_NONE`, `MD_SYNC_SET`, `MD_SYNC_RST`, `MD_SYNC_BOTH`, `MD_ASYNC_PRE`, `MD_ASYNC_CLR` and `MD_ASYNC_BOTH`.

A global-initialisation input loads a separate power-up value at once. That load overrides every other input. The power-up value defaults to the level the primary force input drives, but it can be set on its own. Each control input has its own inversion parameter. A parameter can also tie the clock enable permanently active.

The design is a two-state machine. The states are `ST_LOW` and `ST_HIGH`. On each clock edge it takes exactly one of four transitions: `TR_FORCE_LOW` (a low-level force wins), `TR_FORCE_HIGH` (a high-level force), `TR_LOAD` (enabled capture of `d`) or `TR_HOLD`. A fifth transition, `TR_INIT`, is the asynchronous load of the power-up value. In the asynchronous modes, the force transitions also occur between edges.

Top module: `cfgflop_cell`

## Requirements
- R1: An active primary force input (`sr`) drives `q` to 1 when `SR_HIGH`=1 and to 0 when `SR_HIGH`=0.
- R2: An active secondary force input (`rev`) drives `q` to the complement of the level that `sr` drives.
- R3: When a low-level force and a high-level force are active together, `q` becomes 0. This holds in both synchronous and asynchronous modes.
- R4: With `SR_ASYNC`=0, a force changes `q` only at the next rising edge of `clk`. It takes effect whether or not the clock enable is active.
- R5: With `SR_ASYNC`=1, a force changes `q` without waiting for a clock edge. `q` keeps the forced value after the force is released.
- R6: When no force is active, `q` takes `d` at a rising edge if the enable is active, and holds otherwise. The enable is active high unless it is inverted.
- R7: With `CE_USED`=0, the `ce` port is ignored and capture happens on every edge.
- R8: An active `ginit` sets `q` to the power-up value at once. It overrides `d`, the enable and both force inputs.
- R9: The power-up value `INIT_HIGH` defaults to `SR_HIGH`, and it may be set independently of it.
- R10: `INV_SR`, `INV_REV` and `INV_CE` each make the matching input active low.
- R11: A force input whose use parameter (`SR_USED` / `REV_USED`) is 0 has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| d | input | 1 | Data captured on an enabled edge |
| ce | input | 1 | Clock enable (polarity set by `INV_CE`) |
| sr | input | 1 | Primary force input; drives the `SR_HIGH` level |
| rev | input | 1 | Secondary force input; drives the opposite level |
| ginit | input | 1 | Global initialisation; loads `INIT_HIGH` at once |
| q | output | 1 | Stored value |

## Verification
The hardest case to reach is in asynchronous mode: both forces are active at once, so the only observable effect is that `q` stays low. The other hard case is a synchronous force with the enable off, which should act at the edge but must not act before it. The bench drives the force inputs on the falling clock edge and samples `q` one nanosecond later, well before the next rising edge. A change seen at that point can only come from an asynchronous path. A synchronous force is checked twice: once before the edge, where `q` must not yet have moved, and once after it. For the conflict case, the second force is raised while the first is still held, and both are then released together.

// File: rtl/cfgflop_pkg.sv
package cfgflop_pkg;

    typedef enum logic [2:0] {
        MD_NONE,
        MD_SYNC_SET,
        MD_SYNC_RST,
        MD_SYNC_BOTH,
        MD_ASYNC_PRE,
        MD_ASYNC_CLR,
        MD_ASYNC_BOTH
    } sr_mode_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } store_e;

    typedef enum logic [2:0] {
        TR_INIT,
        TR_FORCE_LOW,
        TR_FORCE_HIGH,
        TR_LOAD,
        TR_HOLD
    } trans_e;

    // Map the use bits onto set/reset roles and pick one of the seven modes.
    function automatic sr_mode_e mode_of(input bit sr_used, input bit rev_used,
                                         input bit sr_high, input bit async_on);
        bit set_used;
        bit rst_used;
        sr_mode_e m;
        set_used = sr_high ? sr_used  : rev_used;
        rst_used = sr_high ? rev_used : sr_used;
        case ({async_on, set_used, rst_used})
            3'b010:  m = MD_SYNC_SET;
            3'b001:  m = MD_SYNC_RST;
            3'b011:  m = MD_SYNC_BOTH;
            3'b110:  m = MD_ASYNC_PRE;
            3'b101:  m = MD_ASYNC_CLR;
            3'b111:  m = MD_ASYNC_BOTH;
            default: m = MD_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgflop_ctrl.sv
module cfgflop_ctrl
    import cfgflop_pkg::*;
#(
    parameter sr_mode_e MODE      = MD_SYNC_BOTH,
    parameter bit       SR_HIGH   = 1'b0,
    parameter bit       CE_USED   = 1'b1,
    parameter bit       INV_CE    = 1'b0,
    parameter bit       INV_SR    = 1'b0,
    parameter bit       INV_REV   = 1'b0,
    parameter bit       INV_GINIT = 1'b0
) (
    input  logic ce,
    input  logic sr,
    input  logic rev,
    input  logic ginit,
    output logic en,
    output logic force_hi,
    output logic force_lo,
    output logic init_act
);

    localparam bit HAS_SET = (MODE == MD_SYNC_SET)  || (MODE == MD_SYNC_BOTH) ||
                             (MODE == MD_ASYNC_PRE) || (MODE == MD_ASYNC_BOTH);
    localparam bit HAS_RST = (MODE == MD_SYNC_RST)  || (MODE == MD_SYNC_BOTH) ||
                             (MODE == MD_ASYNC_CLR) || (MODE == MD_ASYNC_BOTH);

    logic sr_on;
    logic rev_on;
    logic set_src;
    logic rst_src;

    // Per-input polarity correction
    assign sr_on    = sr  ^ INV_SR;
    assign rev_on   = rev ^ INV_REV;
    assign init_act = ginit ^ INV_GINIT;

    generate
        if (CE_USED) begin : g_ce
            assign en = ce ^ INV_CE;
        end else begin : g_ce_tied
            logic unused_ce;
            assign unused_ce = ce;
            assign en = 1'b1;
        end
    endgenerate

    // Route the two force inputs to the set and reset roles
    assign set_src = SR_HIGH ? sr_on  : rev_on;
    assign rst_src = SR_HIGH ? rev_on : sr_on;

    assign force_hi = HAS_SET & set_src;
    assign force_lo = HAS_RST & rst_src;

endmodule

// File: rtl/cfgflop_next.sv
module cfgflop_next
    import cfgflop_pkg::*;
(
    input  store_e cur,
    input  logic   d,
    input  logic   en,
    input  logic   sync_hi,
    input  logic   sync_lo,
    output store_e nxt
);

    trans_e trans;

    // Transition selection: a low-level force beats a high-level force
    always_comb begin
        if (sync_lo) begin
            trans = TR_FORCE_LOW;
        end else if (sync_hi) begin
            trans = TR_FORCE_HIGH;
        end else if (en) begin
            trans = TR_LOAD;
        end else begin
            trans = TR_HOLD;
        end
    end

    always_comb begin
        unique case (trans)
            TR_FORCE_LOW:  nxt = ST_LOW;
            TR_FORCE_HIGH: nxt = ST_HIGH;
            TR_LOAD:       nxt = d ? ST_HIGH : ST_LOW;
            default:       nxt = cur;
        endcase
    end

endmodule

// File: rtl/cfgflop_cell.sv
module cfgflop_cell
    import cfgflop_pkg::*;
#(
    parameter bit SR_HIGH   = 1'b0,
    parameter bit SR_ASYNC  = 1'b0,
    parameter bit SR_USED   = 1'b1,
    parameter bit REV_USED  = 1'b1,
    parameter bit INIT_HIGH = SR_HIGH,
    parameter bit CE_USED   = 1'b1,
    parameter bit INV_CE    = 1'b0,
    parameter bit INV_SR    = 1'b0,
    parameter bit INV_REV   = 1'b0,
    parameter bit INV_GINIT = 1'b0
) (
    input  logic clk,
    input  logic d,
    input  logic ce,
    input  logic sr,
    input  logic rev,
    input  logic ginit,
    output logic q
);

    localparam sr_mode_e MODE    = mode_of(SR_USED, REV_USED, SR_HIGH, SR_ASYNC);
    localparam store_e   INIT_ST = INIT_HIGH ? ST_HIGH : ST_LOW;
    localparam bit       IS_SYNC = !SR_ASYNC;

    logic   en;
    logic   force_hi;
    logic   force_lo;
    logic   init_act;
    logic   sync_hi;
    logic   sync_lo;
    store_e state;
    store_e nxt;

    cfgflop_ctrl #(
        .MODE      (MODE),
        .SR_HIGH   (SR_HIGH),
        .CE_USED   (CE_USED),
        .INV_CE    (INV_CE),
        .INV_SR    (INV_SR),
        .INV_REV   (INV_REV),
        .INV_GINIT (INV_GINIT)
    ) u_ctrl (
        .ce       (ce),
        .sr       (sr),
        .rev      (rev),
        .ginit    (ginit),
        .en       (en),
        .force_hi (force_hi),
        .force_lo (force_lo),
        .init_act (init_act)
    );

    // Forces reach the edge-driven path only in synchronous modes
    assign sync_hi = force_hi & IS_SYNC;
    assign sync_lo = force_lo & IS_SYNC;

    cfgflop_next u_next (
        .cur     (state),
        .d       (d),
        .en      (en),
        .sync_hi (sync_hi),
        .sync_lo (sync_lo),
        .nxt     (nxt)
    );

    // State register
    generate
        if (SR_ASYNC) begin : g_async
            logic   async_any;
            store_e async_val;
            assign async_any = init_act | force_lo | force_hi;
            always_comb begin
                if (init_act) begin
                    async_val = INIT_ST;
                end else if (force_lo) begin
                    async_val = ST_LOW;
                end else begin
                    async_val = ST_HIGH;
                end
            end
            always_ff @(posedge clk or posedge async_any) begin
                if (async_any) begin
                    state <= async_val;
                end else begin
                    state <= nxt;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk or posedge init_act) begin
                if (init_act) begin
                    state <= INIT_ST;
                end else begin
                    state <= nxt;
                end
            end
        end
    endgenerate

    // Output process
    always_comb begin
        q = (state == ST_HIGH);
    end

    // R1, R4: a lone high force lands at the next edge in sync mode
    assert_sync_high_R1: assert property (@(posedge clk) disable iff (init_act)
        (IS_SYNC && force_hi && !force_lo) |=> q);

    // R3: the low force wins at the edge in sync mode
    assert_sync_low_wins_R3: assert property (@(posedge clk) disable iff (init_act)
        (IS_SYNC && force_lo) |=> !q);

    // R6: no force and no enable keeps the value
    assert_hold_R6: assert property (@(posedge clk) disable iff (init_act)
        (IS_SYNC && !force_lo && !force_hi && !en) |=> $stable(q));

    // R5: an asynchronous clear already holding before an edge means q is low
    assert_async_clear_R5: assert property (@(posedge clk) disable iff (init_act)
        (SR_ASYNC && force_lo) |-> !q);

    // R8: during global init the power-up value is present
    assert_init_value_R8: assert property (@(negedge clk)
        init_act |-> (q == INIT_HIGH));

endmodule

// File: tb/cfgflop_cell_tb.sv
module cfgflop_cell_tb;

    logic clk = 1'b0;
    logic ginit;
    int   n_chk  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    // Default instance: SR low, synchronous, INIT from SR
    logic d0, ce0, sr0, rev0, q0;
    // Async, SR high
    logic d1, ce1, sr1, rev1, q1;
    // Inverted controls, INIT high independent of SR low
    logic d2, ce2, sr2, rev2, q2;
    // Mode none, enable tied off
    logic d3, ce3, sr3, rev3, q3;

    cfgflop_cell u_dut (
        .clk(clk), .d(d0), .ce(ce0), .sr(sr0), .rev(rev0), .ginit(ginit), .q(q0));

    cfgflop_cell #(.SR_HIGH(1'b1), .SR_ASYNC(1'b1)) u_dut_async (
        .clk(clk), .d(d1), .ce(ce1), .sr(sr1), .rev(rev1), .ginit(ginit), .q(q1));

    cfgflop_cell #(.INIT_HIGH(1'b1), .INV_CE(1'b1), .INV_SR(1'b1), .INV_REV(1'b1)) u_dut_inv (
        .clk(clk), .d(d2), .ce(ce2), .sr(sr2), .rev(rev2), .ginit(ginit), .q(q2));

    cfgflop_cell #(.SR_USED(1'b0), .REV_USED(1'b0), .CE_USED(1'b0)) u_dut_none (
        .clk(clk), .d(d3), .ce(ce3), .sr(sr3), .rev(rev3), .ginit(ginit), .q(q3));

    // {sr, rev, ce, d, expected q} applied to u_dut, one edge each
    localparam logic [4:0] VEC [8] = '{
        5'b00111, 5'b00001, 5'b10010, 5'b01001,
        5'b11110, 5'b00111, 5'b00100, 5'b01101
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        ginit = 1'b1;
        d0 = 0; ce0 = 0; sr0 = 0; rev0 = 0;
        d1 = 0; ce1 = 0; sr1 = 0; rev1 = 0;
        d2 = 0; ce2 = 1; sr2 = 1; rev2 = 1;
        d3 = 0; ce3 = 0; sr3 = 1; rev3 = 1;
        edge_step();
        edge_step();

        // Reset state and power-up values
        chk("R8 R9 default init low", q0, 1'b0);
        chk("R9 default init follows SR high", q1, 1'b1);
        chk("R9 independent init high", q2, 1'b1);
        chk("R8 init mode none", q3, 1'b0);

        // Global init overrides data, enable and force
        d0 = 1; ce0 = 1; rev0 = 1;
        edge_step();
        chk("R8 init beats rev and d", q0, 1'b0);
        d0 = 0; ce0 = 0; rev0 = 0;
        ginit = 1'b0;
        edge_step();

        // Vector table on the synchronous instance
        for (int i = 0; i < 8; i++) begin
            {sr0, rev0, ce0, d0} = VEC[i][4:1];
            edge_step();
            chk($sformatf("R1/R2/R3/R4/R6 vector %0d", i), q0, VEC[i][0]);
        end

        // R4: a synchronous reset does not act before the edge
        sr0 = 1; rev0 = 0; ce0 = 0; d0 = 1;
        #1;
        chk("R4 no change before edge", q0, 1'b1);
        @(negedge clk);
        chk("R4 reset at edge with enable off", q0, 1'b0);
        sr0 = 0;

        // Asynchronous instance
        d1 = 0; ce1 = 1;
        edge_step();
        chk("R6 async instance load 0", q1, 1'b0);
        ce1 = 0;
        sr1 = 1;
        #1;
        chk("R5 R1 preset immediate", q1, 1'b1);
        @(negedge clk);
        sr1 = 0;
        #1;
        chk("R5 preset value retained", q1, 1'b1);
        @(negedge clk);
        rev1 = 1;
        #1;
        chk("R5 R2 clear immediate", q1, 1'b0);
        @(negedge clk);
        sr1 = 1;
        #1;
        chk("R3 async clear beats preset", q1, 1'b0);
        @(negedge clk);
        sr1 = 0; rev1 = 0;
        #1;
        chk("R5 clear value retained", q1, 1'b0);
        @(negedge clk);

        // Inverted polarities
        d2 = 0; ce2 = 1;
        edge_step();
        chk("R10 ce high disables when inverted", q2, 1'b1);
        ce2 = 0;
        edge_step();
        chk("R10 ce low enables when inverted", q2, 1'b0);
        ce2 = 1; rev2 = 0;
        edge_step();
        chk("R10 R2 rev low sets", q2, 1'b1);
        rev2 = 1; sr2 = 0;
        edge_step();
        chk("R10 R1 sr low resets", q2, 1'b0);
        sr2 = 1;

        // Mode none with enable tied active
        d3 = 1;
        edge_step();
        chk("R11 R7 sr ignored, d captured with ce low", q3, 1'b1);
        d3 = 0;
        edge_step();
        chk("R11 R7 rev ignored, d captured", q3, 1'b0);

        finish_run();
    end

endmodule